// File: doc/BRIEF.md
# Power-Save Clock Divider with Dual Clock Outputs

The block runs from a fast reference clock that is twice the PLL rate. From it, the block builds two square waves. One is a PLL-rate wave that toggles on every reference cycle. The other is the internal processor clock, which either follows the PLL rate or is slowed by a power-of-two divisor while power-save is on. The processor keeps running on the slow clock. A pending interrupt ends power-save without software action. The return to full speed, like every other rate change, waits for the end of a low phase, so no pulse is ever cut short.

Two external clock pins each pick either the processor clock or the PLL-rate wave, and each has its own drive enable. A disabled pin is held low. One 8-bit configuration register holds all settings and can be read back:
- bits [2:0]: divisor code
- bit 3: power-save enable
- bit 4: output A select
- bit 5: output B select
- bit 6: output A drive enable
- bit 7: output B drive enable

Top module: `ps_clk_gen`

## Requirements
- R1: While reset is held, the configuration reads 8'hC0 (both drives on, both selects on the processor clock, power-save off, code 0), and the processor clock and both output pins are low.
- R2: With power-save off, the processor clock toggles on every reference cycle. It first goes high one cycle after reset is released.
- R3: With power-save on and divisor code n in bits [2:0], each high phase and each low phase of the processor clock lasts 2^(n+1) reference cycles. Codes 0 to 6 give 2 to 128 cycles, and code 7 gives 128 cycles, the same as code 6.
- R4: When the interrupt input is high in a cycle, bit 3 reads 0 from the next cycle on. The interrupt wins over a write in the same cycle that sets bit 3. An interrupt while power-save is off changes nothing.
- R5: A new rate takes effect only where the processor clock rises. The half period that is running when the configuration changes finishes at the old length, as does the low half that follows it.
- R6: An enabled output whose select bit is 0 equals the processor clock in every cycle. An enabled output whose select bit is 1 toggles on every reference cycle.
- R7: An output whose drive-enable bit is 0 is held low, starting one cycle after the enable value takes effect.
- R8: A write stores all 8 bits the next cycle, apart from the R4 clearing. Without a write or an interrupt, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the PLL rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| irq | input | 1 | Pending interrupt |
| cfg_rdata | output | 8 | Current configuration |
| proc_clk | output | 1 | Internal processor clock |
| clkout_a | output | 1 | External clock output A |
| clkout_b | output | 1 | External clock output B |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a register write and the interrupt exit. The bench writes a value with bit 3 set in the same cycle that it raises the interrupt. It then expects to read back the written value with bit 3 cleared.

The second pair is a rate change and a running half period. The bench rewrites the divisor partway through a high phase. It then expects the run lengths from the old divisor, followed by the run lengths from the new one.

// File: rtl/ps_clk_pkg.sv
package ps_clk_pkg;

    localparam int CODE_W   = 3;
    localparam int MAX_CODE = 6;
    localparam int HALF_MAX = 1 << (MAX_CODE + 1);
    localparam int HALF_W   = $clog2(HALF_MAX) + 1;
    localparam int N_OUT    = 2;

    typedef struct packed {
        logic [N_OUT-1:0]  drv;
        logic [N_OUT-1:0]  sel;
        logic              ps_on;
        logic [CODE_W-1:0] code;
    } cfg_t;

    localparam int   CFG_W     = $bits(cfg_t);
    localparam cfg_t CFG_RESET = '{drv: '1, sel: '0, ps_on: 1'b0, code: '0};

    function automatic logic [HALF_W-1:0] half_of(input logic [CODE_W-1:0] code,
                                                  input logic              on);
        logic [CODE_W-1:0] c;
        c = (int'(code) > MAX_CODE) ? CODE_W'(MAX_CODE) : code;
        if (!on) return HALF_W'(1);
        return HALF_W'(1) << (c + 1'b1);
    endfunction

endpackage

// File: rtl/ps_cfg_regs.sv
module ps_cfg_regs
    import ps_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             irq,
    output cfg_t             cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we)  cfg_d = cfg_t'(wdata);
        if (irq) cfg_d.ps_on = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_d;
    end

    // R4: interrupt leaves power-save off
    p_irq_exit_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !cfg_q.ps_on);

    // R8: plain write is stored
    p_write_r8: assert property (@(posedge clk) disable iff (rst)
        (we && !irq) |=> (cfg_q == cfg_t'($past(wdata))));

    // R8: idle register holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!we && !irq) |=> $stable(cfg_q));

endmodule

// File: rtl/ps_div_core.sv
module ps_div_core
    import ps_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] target_half,
    output logic              proc_q,
    output logic              pll_q,
    output logic              proc_nx,
    output logic              pll_nx
);

    logic [HALF_W-1:0] cnt, cnt_nx;
    logic [HALF_W-1:0] cur_half, half_nx;
    logic              wrap;

    always_comb begin
        wrap    = (cnt == cur_half - 1'b1);
        proc_nx = wrap ? ~proc_q : proc_q;
        pll_nx  = ~pll_q;
        cnt_nx  = wrap ? '0 : cnt + 1'b1;
        // a new length is adopted only where a low half ends
        half_nx = (wrap && !proc_q) ? target_half : cur_half;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cur_half <= HALF_W'(1);
            proc_q   <= 1'b0;
            pll_q    <= 1'b0;
        end else begin
            cnt      <= cnt_nx;
            cur_half <= half_nx;
            proc_q   <= proc_nx;
            pll_q    <= pll_nx;
        end
    end

    // R5: the half length changes only together with a rising processor clock
    p_len_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_half != $past(cur_half)) |-> $rose(proc_q));

    // R3: phase counter stays inside the active half
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt < cur_half);

endmodule

// File: rtl/ps_out_drive.sv
module ps_out_drive (
    input  logic clk,
    input  logic rst,
    input  logic drv_en,
    input  logic sel_pll,
    input  logic proc_nx,
    input  logic pll_nx,
    input  logic proc_q,
    input  logic pll_q,
    output logic clk_o
);

    always_ff @(posedge clk) begin
        if (rst)          clk_o <= 1'b0;
        else if (!drv_en) clk_o <= 1'b0;
        else              clk_o <= sel_pll ? pll_nx : proc_nx;
    end

    // R7: disabled pin stays low
    p_gated_low_r7: assert property (@(posedge clk) disable iff (rst)
        !drv_en |=> !clk_o);

    // R6: processor-clock selection tracks the divider
    p_follow_proc_r6: assert property (@(posedge clk) disable iff (rst)
        (drv_en && !sel_pll) |=> (clk_o == proc_q));

    // R6: PLL selection tracks the PLL-rate wave
    p_follow_pll_r6: assert property (@(posedge clk) disable iff (rst)
        (drv_en && sel_pll) |=> (clk_o == pll_q));

endmodule

// File: rtl/ps_clk_gen.sv
module ps_clk_gen
    import ps_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             irq,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             proc_clk,
    output logic             clkout_a,
    output logic             clkout_b
);

    cfg_t              cfg_q;
    logic [HALF_W-1:0] target_half;
    logic              proc_q, pll_q, proc_nx, pll_nx;
    logic [N_OUT-1:0]  out_q;

    ps_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .irq   (irq),
        .cfg_q (cfg_q)
    );

    always_comb target_half = half_of(cfg_q.code, cfg_q.ps_on);

    ps_div_core u_div (
        .clk         (clk),
        .rst         (rst),
        .target_half (target_half),
        .proc_q      (proc_q),
        .pll_q       (pll_q),
        .proc_nx     (proc_nx),
        .pll_nx      (pll_nx)
    );

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_out
            ps_out_drive u_drv (
                .clk     (clk),
                .rst     (rst),
                .drv_en  (cfg_q.drv[g]),
                .sel_pll (cfg_q.sel[g]),
                .proc_nx (proc_nx),
                .pll_nx  (pll_nx),
                .proc_q  (proc_q),
                .pll_q   (pll_q),
                .clk_o   (out_q[g])
            );
        end
    endgenerate

    assign cfg_rdata = cfg_q;
    assign proc_clk  = proc_q;
    assign clkout_a  = out_q[0];
    assign clkout_b  = out_q[1];

endmodule

// File: tb/ps_clk_gen_tb.sv
module ps_clk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       irq = 1'b0;
    logic [7:0] cfg_rdata;
    logic       proc_clk, clkout_a, clkout_b;

    int  n_run = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    ps_clk_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .irq       (irq),
        .cfg_rdata (cfg_rdata),
        .proc_clk  (proc_clk),
        .clkout_a  (clkout_a),
        .clkout_b  (clkout_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_rise();
        logic p;
        p = proc_clk;
        @(negedge clk);
        while (!( !p && proc_clk)) begin
            p = proc_clk;
            @(negedge clk);
        end
    endtask

    task automatic meas(output int hi, output int lo);
        wait_rise();
        hi = 0;
        while (proc_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!proc_clk) begin lo++; @(negedge clk); end
    endtask

    initial begin
        int hi, lo, hi2, exp;
        logic pb;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cfg_rdata == 8'hC0, "R1 cfg", cfg_rdata, 8'hC0);
        chk(!proc_clk && !clkout_a && !clkout_b, "R1 clocks low",
            {proc_clk, clkout_a, clkout_b}, 0);
        rst = 1'b0;
        // R2: full speed after reset, R6 output A follows
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk(proc_clk == k[0], "R2 toggle", proc_clk, k[0]);
            chk(clkout_a == proc_clk, "R6 A=proc", clkout_a, proc_clk);
        end
        // R3: sweep all divisor codes
        for (int c = 0; c < 8; c++) begin
            wr(8'hC8 | 8'(c));
            exp = 2 << ((c > 6) ? 6 : c);
            meas(hi, lo);
            chk(hi == exp, "R3 high", hi, exp);
            chk(lo == exp, "R3 low", lo, exp);
        end
        // back to full speed
        wr(8'hC0);
        meas(hi, lo);
        chk(hi == 1 && lo == 1, "R2 return", hi * 100 + lo, 101);
        // R5: divisor rewritten mid high phase
        wr(8'hCB);
        meas(hi, lo);
        chk(hi == 16, "R5 settle", hi, 16);
        wait_rise();
        hi = 1;
        cfg_we = 1'b1; cfg_wdata = 8'hCD;
        @(negedge clk);
        cfg_we = 1'b0;
        while (proc_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!proc_clk) begin lo++; @(negedge clk); end
        hi2 = 0;
        while (proc_clk) begin hi2++; @(negedge clk); end
        chk(hi == 16, "R5 old high", hi, 16);
        chk(lo == 16, "R5 old low", lo, 16);
        chk(hi2 == 64, "R5 new high", hi2, 64);
        // R4: interrupt exit from power-save
        wr(8'hCB);
        meas(hi, lo);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        chk(cfg_rdata == 8'hC3, "R4 exit", cfg_rdata, 8'hC3);
        meas(hi, lo);
        chk(hi == 1 && lo == 1, "R4 full speed", hi * 100 + lo, 101);
        // R4 + R8: interrupt and write in the same cycle
        cfg_we = 1'b1; cfg_wdata = 8'hC9; irq = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; irq = 1'b0;
        chk(cfg_rdata == 8'hC1, "R4 priority", cfg_rdata, 8'hC1);
        // R4: interrupt with power-save off
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        chk(cfg_rdata == 8'hC1, "R4 no effect", cfg_rdata, 8'hC1);
        pb = proc_clk;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(proc_clk != pb, "R4 still full", proc_clk, !pb);
            pb = proc_clk;
        end
        // R6 + R8: A on processor clock, B on PLL
        wr(8'hEA);
        chk(cfg_rdata == 8'hEA, "R8 readback", cfg_rdata, 8'hEA);
        @(negedge clk);
        pb = clkout_b;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk(clkout_a == proc_clk, "R6 A=proc", clkout_a, proc_clk);
            chk(clkout_b != pb, "R6 B=pll", clkout_b, !pb);
            pb = clkout_b;
        end
        // R7: both disabled
        wr(8'h3A);
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(!clkout_a && !clkout_b, "R7 off", {clkout_a, clkout_b}, 0);
        end
        // R6/R7: A on PLL, B disabled
        wr(8'h5A);
        chk(cfg_rdata == 8'h5A, "R8 readback2", cfg_rdata, 8'h5A);
        @(negedge clk);
        pb = clkout_a;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(clkout_a != pb, "R6 A=pll", clkout_a, !pb);
            chk(!clkout_b, "R7 B off", clkout_b, 0);
            pb = clkout_a;
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule